// File: doc/BRIEF.md
# Late-Write Synchronous Byte-Write SRAM

This block is a single-port synchronous static memory whose write data trails its address by one clock. On every rising edge it registers an address, an active-low select, an active-low write strobe and four active-low byte enables. A read returns the whole 36-bit word in the next cycle. For a write, the address and byte mask wait in a pending-write register. At the following edge the data is taken from the data input and the enabled bytes are written into the array.

The data bus is split into a data input, a data output and an output enable. The output enable is high only in the cycle after a registered read. A read of the address whose write is being committed at that same edge returns the merged new word. A sleep input freezes the block, drops anything in the pipeline and releases the bus. The word is four 9-bit bytes, and the depth is a parameter.

Top module: `lw_sram`

## Requirements
- R1: A read (sel_n=0, wr_n=1) registered at edge t gives dout_oe=1 and dout equal to the whole stored word after edge t, until edge t+1. ben_n has no effect on a read.
- R2: A write (sel_n=0, wr_n=0) registered at edge t stores the din value sampled at edge t+1, whatever command is presented at t+1.
- R3: ben_n[0], [1], [2] and [3] (active low) guard din bits 8:0, 17:9, 26:18 and 35:27. Only enabled bytes change, and any combination may be enabled.
- R4: A write with ben_n=4'b1111 is aborted. No stored byte changes and dout_oe stays 0.
- R5: An edge with sel_n=1 is a deselect. dout_oe is 0 after that edge, whatever wr_n is, and nothing is stored.
- R6: While sleep=1, dout_oe is 0 at once and edges are ignored. A pending write is dropped, not committed. After sleep falls, the block behaves as if idle.
- R7: dout_oe is 0 in the cycle after a write is registered and in the cycle after its data is captured, unless that data edge also registers a read.
- R8: A read registered at the same edge that commits a write to the same address returns the old word with the enabled bytes replaced by the din sampled at that edge.
- R9: While rst_n=0, and after reset, dout_oe is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep | input | 1 | High: ignore clock, drop pipeline, release bus |
| sel_n | input | 1 | Active-low select, registered |
| wr_n | input | 1 | Active-low write strobe, registered |
| ben_n | input | 4 | Active-low byte enables, registered, writes only |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| din | input | 36 | Write data, sampled one edge after its command |
| dout | output | 36 | Read data |
| dout_oe | output | 1 | High when dout should drive the bus |

## Verification
The assertions assume that every control input is a known value at each rising edge once reset has been released. They also assume that no command is issued during the two cycles the internal reset synchronizer needs, because the checker follows the external reset pin. The stimulus keeps sel_n high and sleep low throughout reset and for several cycles after it. It changes inputs only one time unit after a rising edge, so every sampled control is defined and stable.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int BYTE_W = 9;
  localparam int NBYTES = 4;
  localparam int WORD_W = BYTE_W * NBYTES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NBYTES-1:0] bmask_t;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_ABORT = 2'd3
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic sel_n, input logic wr_n,
                                      input bmask_t ben_n);
    cmd_e c;
    if (sel_n)            c = CMD_IDLE;
    else if (wr_n)        c = CMD_READ;
    else if (&ben_n)      c = CMD_ABORT;
    else                  c = CMD_WRITE;
    return c;
  endfunction
endpackage

// File: rtl/lw_rst_sync.sv
module lw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          sel_n,
  input  logic          wr_n,
  input  bmask_t        ben_n,
  input  logic [AW-1:0] addr,
  output logic          rd_fire,
  output logic          rd_vld,
  output logic          pend_vld,
  output logic [AW-1:0] pend_addr,
  output bmask_t        pend_mask
);
  cmd_e          cmd;
  logic          pend_vld_d;
  logic [AW-1:0] pend_addr_d;
  bmask_t        pend_mask_d;
  logic          rd_vld_d;
  logic          cap_en;

  always_comb begin
    cmd         = decode_cmd(sel_n, wr_n, ben_n);
    rd_fire     = !sleep && (cmd == CMD_READ);
    cap_en      = !sleep && (cmd == CMD_WRITE);
    rd_vld_d    = rd_fire;
    pend_vld_d  = cap_en;
    pend_addr_d = pend_addr;
    pend_mask_d = pend_mask;
    if (cap_en) begin
      pend_addr_d = addr;
      pend_mask_d = ~ben_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld    <= 1'b0;
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
    end else begin
      rd_vld    <= rd_vld_d;
      pend_vld  <= pend_vld_d;
      pend_addr <= pend_addr_d;
      pend_mask <= pend_mask_d;
    end
  end
endmodule

// File: rtl/lw_store.sv
module lw_store
  import lw_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  bmask_t        wmask,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_bank
    logic [BYTE_W-1:0] bank [DEPTH];
    logic              bank_we;

    assign bank_we = we && wmask[b];

    always_ff @(posedge clk) begin
      if (bank_we) bank[waddr] <= wdata[b*BYTE_W +: BYTE_W];
    end

    assign rdata[b*BYTE_W +: BYTE_W] = bank[raddr];
  end
endmodule

// File: rtl/lw_fwd.sv
module lw_fwd
  import lw_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          pend_vld,
  input  logic [AW-1:0] pend_addr,
  input  bmask_t        pend_mask,
  input  logic [AW-1:0] raddr,
  input  word_t         array_word,
  input  word_t         new_word,
  output word_t         merged
);
  logic hit;

  assign hit = pend_vld && (pend_addr == raddr);

  for (genvar b = 0; b < NBYTES; b++) begin : g_sel
    assign merged[b*BYTE_W +: BYTE_W] = (hit && pend_mask[b])
                                        ? new_word[b*BYTE_W +: BYTE_W]
                                        : array_word[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic [3:0]    ben_n,
  input  logic [AW-1:0] addr,
  input  logic [35:0]   din,
  output logic [35:0]   dout,
  output logic          dout_oe
);
  logic          rst_n_i;
  logic          rd_fire;
  logic          rd_vld;
  logic          pend_vld;
  logic [AW-1:0] pend_addr;
  bmask_t        pend_mask;
  logic          commit;
  word_t         array_word;
  word_t         merged;
  word_t         dout_q;
  word_t         dout_d;

  lw_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  lw_cmd_stage #(.AW(AW)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sleep     (sleep),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .ben_n     (ben_n),
    .addr      (addr),
    .rd_fire   (rd_fire),
    .rd_vld    (rd_vld),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr),
    .pend_mask (pend_mask)
  );

  assign commit = pend_vld && !sleep && rst_n_i;

  lw_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (commit),
    .waddr (pend_addr),
    .wmask (pend_mask),
    .wdata (din),
    .raddr (addr),
    .rdata (array_word)
  );

  lw_fwd #(.AW(AW)) u_fwd (
    .pend_vld   (commit),
    .pend_addr  (pend_addr),
    .pend_mask  (pend_mask),
    .raddr      (addr),
    .array_word (array_word),
    .new_word   (din),
    .merged     (merged)
  );

  always_comb begin
    dout_d = dout_q;
    if (rd_fire) dout_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) dout_q <= '0;
    else          dout_q <= dout_d;
  end

  assign dout    = dout_q;
  assign dout_oe = rd_vld && !sleep;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          sel_n,
  input logic          wr_n,
  input logic [3:0]    ben_n,
  input logic          dout_oe
);
  logic rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= !sleep && !sel_n && wr_n;
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && wr_n) |=> (dout_oe || sleep)); // R1

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && !wr_n && (ben_n == 4'hF)) |=> !dout_oe); // R4

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !dout_oe); // R5

  AST_SLEEP_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_oe); // R6

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n) |=> !dout_oe); // R7

  AST_OE_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> rd_seen); // R7

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!dout_oe || $isunknown(dout_oe)); // R9
  end
endmodule

bind lw_sram lw_sram_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sleep   (sleep),
  .sel_n   (sel_n),
  .wr_n    (wr_n),
  .ben_n   (ben_n),
  .dout_oe (dout_oe)
);

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep;
  logic          sel_n;
  logic          wr_n;
  logic [3:0]    ben_n;
  logic [AW-1:0] addr;
  logic [35:0]   din;
  logic [35:0]   dout;
  logic          dout_oe;

  int nvec  = 0;
  int nfail = 0;
  logic [35:0] model [DEPTH];

  always #2.5 clk = ~clk;

  lw_sram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
    .ben_n(ben_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [35:0] pat(input int a, input int k);
    logic [35:0] v;
    v = 36'(a) * 36'h0_1357_9BDF + 36'(k) * 36'h8_6420_ECA9 + 36'h5_A5A5_A5A5;
    return v;
  endfunction

  function automatic logic [35:0] expand(input logic [3:0] m_n);
    logic [35:0] e;
    for (int b = 0; b < 4; b++) e[b*9 +: 9] = m_n[b] ? 9'h000 : 9'h1FF;
    return e;
  endfunction

  task automatic chk(input string req, input logic [35:0] act,
                     input logic [35:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [3:0] be,
                      input int a, input logic [35:0] d);
    sel_n = s; wr_n = w; ben_n = be; addr = AW'(a); din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic [35:0] d);
    step(1'b1, 1'b1, 4'hF, 0, d);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sleep = 1'b0; sel_n = 1'b1; wr_n = 1'b1;
    ben_n = 4'hF; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 oe in reset", 36'(dout_oe), 36'd0);
    rst_n = 1'b1;
    repeat (4) idle('0);
    chk("R9 oe after reset", 36'(dout_oe), 36'd0);

    // R2: back-to-back full writes, data of each on the next edge
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 1'b0, 4'h0, a, (a == 0) ? 36'h0 : pat(a - 1, 0));
      chk("R7 oe after write", 36'(dout_oe), 36'd0);
      model[a] = pat(a, 0);
    end
    idle(pat(DEPTH - 1, 0));
    chk("R7 oe after data edge", 36'(dout_oe), 36'd0);

    // R1: back-to-back reads, byte enables varied and ignored
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 1'b1, 4'(a), a, 36'hF_FFFF_FFFF);
      chk("R1 oe", 36'(dout_oe), 36'd1);
      chk("R2 R1 read data", dout, model[a]);
    end
    idle('0);
    chk("R5 oe after deselect", 36'(dout_oe), 36'd0);

    // R3 and R4: every byte-enable pattern on several addresses
    for (int a = 0; a < 4; a++) begin
      for (int m = 0; m < 16; m++) begin
        logic [35:0] nw;
        nw = pat(a + 7, m + 1);
        step(1'b0, 1'b0, 4'(m), a, '0);
        chk("R7 R4 oe after write cmd", 36'(dout_oe), 36'd0);
        idle(nw);
        chk("R7 R4 oe after data", 36'(dout_oe), 36'd0);
        model[a] = (model[a] & ~expand(4'(m))) | (nw & expand(4'(m)));
        step(1'b0, 1'b1, 4'h0, a, '0);
        chk("R3 R4 merged word", dout, model[a]);
      end
    end

    // R8: read at the very edge that commits the write
    for (int m = 0; m < 16; m++) begin
      logic [35:0] nw;
      int a;
      a = 8 + (m % 4);
      nw = pat(m, 99);
      step(1'b0, 1'b0, 4'(m), a, '0);
      step(1'b0, 1'b1, 4'hF, a, nw);
      model[a] = (model[a] & ~expand(4'(m))) | (nw & expand(4'(m)));
      chk("R8 forwarded oe", 36'(dout_oe), 36'd1);
      chk("R8 forwarded data", dout, model[a]);
    end
    // R8: a read of a different address is not forwarded
    step(1'b0, 1'b0, 4'h0, 12, '0);
    step(1'b0, 1'b1, 4'h0, 13, pat(12, 5));
    model[12] = pat(12, 5);
    chk("R8 other address", dout, model[13]);
    step(1'b0, 1'b1, 4'h0, 12, '0);
    chk("R8 committed", dout, model[12]);

    // R5: deselect with write strobe low stores nothing
    step(1'b1, 1'b0, 4'h0, 14, '0);
    chk("R5 oe", 36'(dout_oe), 36'd0);
    idle(36'h0_DEAD_BEEF);
    step(1'b0, 1'b1, 4'h0, 14, '0);
    chk("R5 nothing stored", dout, model[14]);
    step(1'b1, 1'b1, 4'h0, 14, '0);
    chk("R5 oe after read then deselect", 36'(dout_oe), 36'd0);

    // R6: sleep releases the bus at once
    step(1'b0, 1'b1, 4'h0, 3, '0);
    chk("R6 read before sleep", dout, model[3]);
    sleep = 1'b1;
    #1;
    chk("R6 oe drops with sleep", 36'(dout_oe), 36'd0);
    sleep = 1'b0;
    // R6: pending write dropped by sleep on its data edge
    step(1'b0, 1'b0, 4'h0, 15, '0);
    sleep = 1'b1;
    step(1'b0, 1'b1, 4'h0, 15, 36'h1_2345_6789);
    chk("R6 oe asleep", 36'(dout_oe), 36'd0);
    step(1'b0, 1'b1, 4'h0, 15, 36'h1_2345_6789);
    chk("R6 read ignored asleep", 36'(dout_oe), 36'd0);
    sleep = 1'b0;
    idle(36'h1_2345_6789);
    chk("R6 clean after wake", 36'(dout_oe), 36'd0);
    step(1'b0, 1'b1, 4'h0, 15, '0);
    chk("R6 write dropped", dout, model[15]);
    idle('0);

    finish_run();
  end
endmodule